// File: doc/BRIEF.md
# Switchable Line Coder for a Low-Rate RF Transmitter

This block turns a short serial frame into the control signals of a low-rate RF transmitter. Software first fills a small shift buffer and sets a bit count. A start pulse then sends the frame MSB first. Each data bit takes two half-bit periods, and each half-bit ends on a pulse of an external half-bit-rate tick. A two-bit mode field chooses the coding: Manchester, Bi-Phase or NRZ from the buffer. A fourth mode bypasses the buffer and makes the line follow a single data bit that software writes directly. One invert control flips the coded level in every mode.

The coded level then drives the carrier controls. With frequency-shift keying, the carrier stays on for the whole frame and the level picks one of two 13-bit frequency words. With on-off keying, a high level turns the carrier on using the second word, and a low level turns it off. A band-select bit is passed through so that the synthesizer can pick its band. Configuration written during a frame is held in a staging copy and takes effect only between two data bits.

Top module: `rfenc_top`

## Requirements
- R1: After `rst_n` low or a one-cycle `rf_srst`, all settings are zero: Manchester mode, no inversion, band 0, FSK, both frequency words 0 and the Bi-Phase level low. The block is idle, so `busy`, `line`, `car_en`, `car_sel` and `freq_word` are all 0.
- R2: Settings are written with `cfg_we`, `cfg_addr` and `cfg_wdata`. The settings registers are:
  - Address 0 holds the controls: bits [1:0] mode (00 Manchester, 01 Bi-Phase, 10 NRZ, 11 direct), bit 2 invert, bit 3 band select, bit 4 OOK, bit 5 direct data bit.
  - Address 1 holds the frequency word for a low level.
  - Address 2 holds the frequency word for a high level.
  - Address 3 holds the bit count minus one, in bits [3:0].

  When the block is idle, a write shows at the outputs two clock cycles after the write cycle. `car_sel` follows the band-select bit.
- R3: `start` while idle begins a frame of (count+1) bits, taken MSB first from the buffer. Each bit takes two half-bit periods, and each half-bit ends at an `hb_tick` edge. `busy` is high from the edge that accepts `start` until the tick edge that ends the last half-bit, which is 2×bits×(tick period) cycles.
- R4: In Manchester mode, a 1 is sent as high then low, and a 0 as low then high, before inversion.
- R5: In Bi-Phase mode, the level toggles at the start of every bit and toggles again at mid-bit for a 1. The level is kept from one frame to the next.
- R6: In NRZ mode, the level equals the data bit for both halves of the bit.
- R7: In direct mode, `line` equals the direct data bit XOR invert, whatever `busy` and `hb_tick` do. The carrier is on in FSK and follows `line` in OOK.
- R8: With invert set, every coded level is inverted, in direct mode too.
- R9: In FSK, `car_en` is high while `busy`, and `freq_word` is the high-level word when `line` is 1 and the low-level word otherwise.
- R10: In OOK, `car_en` equals `line` while `busy`, and `freq_word` is the high-level word.
- R11: In the buffer modes, once the frame has ended, `car_en` and `line` are 0.
- R12: `buf_load` and `start` while `busy` have no effect on the frame being sent.
- R13: A settings write made while `busy` takes effect only at the next boundary between two bits, or after the frame ends. The current bit is never changed partway through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_srst | input | 1 | Synchronous reset of settings and sequencer |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 2 | Settings register select |
| cfg_wdata | input | 13 | Settings write data |
| buf_load | input | 1 | Load the frame buffer when idle |
| buf_data | input | 16 | Frame buffer contents, MSB sent first |
| start | input | 1 | Begin a frame when idle |
| hb_tick | input | 1 | One-cycle pulse per half-bit period |
| busy | output | 1 | Frame in progress |
| line | output | 1 | Coded data level |
| car_en | output | 1 | Carrier enable |
| car_sel | output | 1 | Band select |
| freq_word | output | 13 | Selected carrier frequency word |

## Verification
The hardest case to reach from the ports is a settings write that lands inside a data bit, where the change must wait for the next bit boundary. To get there, the bench aligns `start` with a tick so that every half-bit has a known length. It then changes the invert control a few cycles into the first bit of an NRZ frame of all ones, and expects an uninverted first bit followed by inverted bits. A second case pulses `buf_load` and `start` in the middle of a Manchester frame and expects the frame, and its `busy` length, to be unchanged. Bi-Phase frames are sent back to back, and again after `rf_srst`, to show that the carried level persists between frames and is cleared by that reset.

// File: rtl/rfenc_pkg.sv
package rfenc_pkg;

  typedef enum logic [1:0] {
    CODE_MAN = 2'b00,
    CODE_BIP = 2'b01,
    CODE_NRZ = 2'b10,
    CODE_DIR = 2'b11
  } code_e;

  // Control word layout: [1:0] code, [2] invert, [3] band, [4] ook, [5] direct bit
  typedef struct packed {
    logic  dbit;
    logic  ook;
    logic  cf;
    logic  pol;
    code_e code;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_WLO  = 2'd1;
  localparam logic [1:0] ADDR_WHI  = 2'd2;
  localparam logic [1:0] ADDR_LEN  = 2'd3;

endpackage

// File: rtl/rfenc_cfg.sv
module rfenc_cfg
  import rfenc_pkg::*;
#(
  parameter int FW = 13,
  parameter int BW = 16,
  localparam int CW = (BW > 1) ? $clog2(BW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [FW-1:0] wdata,
  input  logic          apply,
  output ctrl_t         act_ctrl,
  output logic [FW-1:0] act_wlo,
  output logic [FW-1:0] act_whi,
  output logic [CW-1:0] act_last
);

  ctrl_t         stg_ctrl_q, stg_ctrl_d;
  logic [FW-1:0] stg_wlo_q, stg_wlo_d;
  logic [FW-1:0] stg_whi_q, stg_whi_d;
  logic [CW-1:0] stg_last_q, stg_last_d;

  ctrl_t         act_ctrl_q;
  logic [FW-1:0] act_wlo_q, act_whi_q;
  logic [CW-1:0] act_last_q;

  // staging copy: written at once
  always_comb begin
    stg_ctrl_d = stg_ctrl_q;
    stg_wlo_d  = stg_wlo_q;
    stg_whi_d  = stg_whi_q;
    stg_last_d = stg_last_q;
    if (we) begin
      unique case (addr)
        ADDR_CTRL: stg_ctrl_d = ctrl_t'(wdata[5:0]);
        ADDR_WLO:  stg_wlo_d  = wdata;
        ADDR_WHI:  stg_whi_d  = wdata;
        ADDR_LEN:  stg_last_d = wdata[CW-1:0];
        default:   stg_ctrl_d = stg_ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_ctrl_q <= '0;
      stg_wlo_q  <= '0;
      stg_whi_q  <= '0;
      stg_last_q <= '0;
    end else if (srst) begin
      stg_ctrl_q <= '0;
      stg_wlo_q  <= '0;
      stg_whi_q  <= '0;
      stg_last_q <= '0;
    end else begin
      stg_ctrl_q <= stg_ctrl_d;
      stg_wlo_q  <= stg_wlo_d;
      stg_whi_q  <= stg_whi_d;
      stg_last_q <= stg_last_d;
    end
  end

  // active copy: enabled only when idle or at a bit boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctrl_q <= '0;
      act_wlo_q  <= '0;
      act_whi_q  <= '0;
      act_last_q <= '0;
    end else if (srst) begin
      act_ctrl_q <= '0;
      act_wlo_q  <= '0;
      act_whi_q  <= '0;
      act_last_q <= '0;
    end else if (apply) begin
      act_ctrl_q <= stg_ctrl_q;
      act_wlo_q  <= stg_wlo_q;
      act_whi_q  <= stg_whi_q;
      act_last_q <= stg_last_q;
    end
  end

  assign act_ctrl = act_ctrl_q;
  assign act_wlo  = act_wlo_q;
  assign act_whi  = act_whi_q;
  assign act_last = act_last_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n || srst)
    !apply |=> ($stable(act_ctrl_q) && $stable(act_wlo_q) && $stable(act_whi_q) && $stable(act_last_q)))
    else $error("active settings changed inside a bit"); // R13

endmodule

// File: rtl/rfenc_seq.sv
module rfenc_seq #(
  parameter int BW = 16,
  localparam int CW = (BW > 1) ? $clog2(BW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          load,
  input  logic [BW-1:0] load_data,
  input  logic          start,
  input  logic          tick,
  input  logic [CW-1:0] last_idx,
  output logic          busy,
  output logic          half,
  output logic          cur_bit,
  output logic          go,
  output logic          mid,
  output logic          bnd
);

  logic [BW-1:0] sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          half_q, half_d;
  logic          fin;

  assign go  = start & ~busy_q;
  assign mid = busy_q & tick & ~half_q;
  assign bnd = busy_q & tick & half_q & (cnt_q != '0);
  assign fin = busy_q & tick & half_q & (cnt_q == '0);

  always_comb begin
    sreg_d = sreg_q;
    if (load && !busy_q) begin
      sreg_d = load_data;
    end else if (bnd) begin
      sreg_d = {sreg_q[BW-2:0], 1'b0};
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    half_d = half_q;
    if (go) begin
      cnt_d  = last_idx;
      busy_d = 1'b1;
      half_d = 1'b0;
    end else if (mid) begin
      half_d = 1'b1;
    end else if (bnd) begin
      cnt_d  = cnt_q - CW'(1);
      half_d = 1'b0;
    end else if (fin) begin
      busy_d = 1'b0;
      half_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      half_q <= 1'b0;
    end else if (srst) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      half_q <= half_d;
    end
  end

  assign busy    = busy_q;
  assign half    = half_q;
  assign cur_bit = sreg_q[BW-1];

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n || srst)
    busy_q && !tick |=> busy_q)
    else $error("frame ended without a tick"); // R3

  AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n || srst)
    busy_q && !tick |=> ($stable(sreg_q) && $stable(cnt_q)))
    else $error("buffer or count disturbed during a frame"); // R12

endmodule

// File: rtl/rfenc_coder.sv
module rfenc_coder
  import rfenc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst,
  input  code_e code,
  input  logic  pol,
  input  logic  dbit,
  input  logic  busy,
  input  logic  half,
  input  logic  d,
  input  logic  go,
  input  logic  mid,
  input  logic  bnd,
  output logic  lvl
);

  logic bp_q, bp_d;
  logic raw;

  // Bi-Phase level: flips at each bit start, and at mid-bit for a one
  always_comb begin
    bp_d = bp_q;
    if (code == CODE_BIP) begin
      if (go || bnd || (mid && d)) begin
        bp_d = ~bp_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= 1'b0;
    end else if (srst) begin
      bp_q <= 1'b0;
    end else begin
      bp_q <= bp_d;
    end
  end

  always_comb begin
    unique case (code)
      CODE_MAN: raw = half ? ~d : d;
      CODE_BIP: raw = bp_q;
      CODE_NRZ: raw = d;
      CODE_DIR: raw = dbit;
      default:  raw = 1'b0;
    endcase
  end

  always_comb begin
    if (code == CODE_DIR) begin
      lvl = raw ^ pol;
    end else begin
      lvl = busy ? (raw ^ pol) : 1'b0;
    end
  end

endmodule

// File: rtl/rfenc_top.sv
module rfenc_top
  import rfenc_pkg::*;
#(
  parameter int FW = 13,
  parameter int BW = 16,
  localparam int CW = (BW > 1) ? $clog2(BW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rf_srst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [FW-1:0] cfg_wdata,
  input  logic          buf_load,
  input  logic [BW-1:0] buf_data,
  input  logic          start,
  input  logic          hb_tick,
  output logic          busy,
  output logic          line,
  output logic          car_en,
  output logic          car_sel,
  output logic [FW-1:0] freq_word
);

  ctrl_t         act_ctrl;
  logic [FW-1:0] act_wlo, act_whi;
  logic [CW-1:0] act_last;
  logic          apply;
  logic          seq_busy, seq_half, seq_bit, seq_go, seq_mid, seq_bnd;
  logic          lvl;
  logic          direct;

  assign apply = ~seq_busy | seq_bnd;

  rfenc_cfg #(.FW(FW), .BW(BW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (rf_srst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .apply    (apply),
    .act_ctrl (act_ctrl),
    .act_wlo  (act_wlo),
    .act_whi  (act_whi),
    .act_last (act_last)
  );

  rfenc_seq #(.BW(BW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (rf_srst),
    .load      (buf_load),
    .load_data (buf_data),
    .start     (start),
    .tick      (hb_tick),
    .last_idx  (act_last),
    .busy      (seq_busy),
    .half      (seq_half),
    .cur_bit   (seq_bit),
    .go        (seq_go),
    .mid       (seq_mid),
    .bnd       (seq_bnd)
  );

  rfenc_coder u_coder (
    .clk   (clk),
    .rst_n (rst_n),
    .srst  (rf_srst),
    .code  (act_ctrl.code),
    .pol   (act_ctrl.pol),
    .dbit  (act_ctrl.dbit),
    .busy  (seq_busy),
    .half  (seq_half),
    .d     (seq_bit),
    .go    (seq_go),
    .mid   (seq_mid),
    .bnd   (seq_bnd),
    .lvl   (lvl)
  );

  assign direct = (act_ctrl.code == CODE_DIR);

  // carrier mapping
  always_comb begin
    if (direct || seq_busy) begin
      car_en = act_ctrl.ook ? lvl : 1'b1;
    end else begin
      car_en = 1'b0;
    end
    freq_word = (act_ctrl.ook || lvl) ? act_whi : act_wlo;
  end

  assign busy    = seq_busy;
  assign line    = lvl;
  assign car_sel = act_ctrl.cf;

  AST_MAN_FLIP: assert property (@(posedge clk) disable iff (!rst_n || rf_srst)
    seq_busy && (act_ctrl.code == CODE_MAN) && hb_tick && !seq_half |=> line != $past(line))
    else $error("Manchester bit lacks a mid-bit transition"); // R4

  AST_NRZ_STEADY: assert property (@(posedge clk) disable iff (!rst_n || rf_srst)
    seq_busy && (act_ctrl.code == CODE_NRZ) && !hb_tick |=> $stable(line))
    else $error("NRZ level moved without a tick"); // R6

endmodule

// File: tb/sim_rfenc_top.sv
module sim_rfenc_top;
  localparam int FW = 13;
  localparam int BW = 16;
  localparam int P  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rf_srst = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [FW-1:0] cfg_wdata = '0;
  logic          buf_load = 1'b0;
  logic [BW-1:0] buf_data = '0;
  logic          start = 1'b0;
  logic          hb_tick = 1'b0;
  logic          busy, line, car_en, car_sel;
  logic [FW-1:0] freq_word;

  always #10 clk = ~clk;

  rfenc_top #(.FW(FW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .rf_srst(rf_srst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .buf_load(buf_load), .buf_data(buf_data), .start(start),
    .hb_tick(hb_tick), .busy(busy), .line(line), .car_en(car_en), .car_sel(car_sel),
    .freq_word(freq_word)
  );

  int total = 0;
  int bad = 0;
  int tcnt = 0;
  int busy_cyc = 0;
  string curreq = "R3";
  logic [FW+1:0] expq[$];

  logic [1:0]    s_code = 2'b00;
  logic          s_pol = 1'b0, s_cf = 1'b0, s_ook = 1'b0, s_dbit = 1'b0, s_bp = 1'b0;
  logic [FW-1:0] s_wlo = '0, s_whi = '0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // half-bit tick generator
  initial forever begin
    @(negedge clk);
    tcnt = (tcnt == P-1) ? 0 : tcnt + 1;
    hb_tick = (tcnt == P-1);
  end

  // scoreboard monitor: one sample in the middle of each half-bit
  initial forever begin
    @(negedge clk);
    #2;
    if (busy === 1'b1) begin
      busy_cyc++;
      if (tcnt == P/2) begin
        if (expq.size() == 0) begin
          check(curreq, "unexpected half-bit", 32'd1, 32'd0);
        end else begin
          logic [FW+1:0] e;
          e = expq.pop_front();
          check(curreq, "half-bit {line,car_en,freq}", {17'd0, line, car_en, freq_word}, {17'd0, e});
        end
      end
    end
  end

  function automatic logic [FW+1:0] item(input logic lv);
    return {lv, (s_ook ? lv : 1'b1), ((s_ook || lv) ? s_whi : s_wlo)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [FW-1:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
    case (a)
      2'd0: begin s_code = d[1:0]; s_pol = d[2]; s_cf = d[3]; s_ook = d[4]; s_dbit = d[5]; end
      2'd1: s_wlo = d;
      2'd2: s_whi = d;
      default: ;
    endcase
  endtask

  task automatic wr_ctrl(input logic [1:0] code, input logic pol, input logic cf, input logic ook, input logic db);
    wr(2'd0, {7'd0, db, ook, cf, pol, code});
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  task automatic load(input logic [BW-1:0] d);
    @(negedge clk); #1;
    buf_load = 1'b1; buf_data = d;
    @(negedge clk); #1;
    buf_load = 1'b0;
  endtask

  task automatic push_frame(input logic [BW-1:0] data, input int n);
    for (int i = 0; i < n; i++) begin
      logic d, h0, h1;
      d = data[BW-1-i];
      case (s_code)
        2'b00: begin h0 = d; h1 = ~d; end
        2'b01: begin s_bp = ~s_bp; h0 = s_bp; if (d) s_bp = ~s_bp; h1 = s_bp; end
        default: begin h0 = d; h1 = d; end
      endcase
      expq.push_back(item(h0 ^ s_pol));
      expq.push_back(item(h1 ^ s_pol));
    end
  endtask

  task automatic fire();
    do begin @(negedge clk); #1; end while (tcnt != P-1);
    busy_cyc = 0;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_frame(input int n);
    do begin @(negedge clk); #3; end while (busy === 1'b1);
    check(curreq, "R3 half-bits left unsent", expq.size(), 0);
    check(curreq, "R3 busy cycles", busy_cyc, 2*n*P);
    check(curreq, "R11 idle car_en", {31'd0, car_en}, 0);
    check(curreq, "R11 idle line", {31'd0, line}, 0);
    expq.delete();
  endtask

  task automatic run(input string req, input logic [BW-1:0] data, input int n);
    curreq = req;
    wr(2'd3, FW'(n-1));
    load(data);
    push_frame(data, n);
    fire();
    finish_frame(n);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    settle();
    // R1 reset state
    check("R1", "busy", {31'd0, busy}, 0);
    check("R1", "car_en", {31'd0, car_en}, 0);
    check("R1", "line", {31'd0, line}, 0);
    check("R1", "car_sel", {31'd0, car_sel}, 0);
    check("R1", "freq_word", {19'd0, freq_word}, 0);

    wr(2'd1, 13'h0123);
    wr(2'd2, 13'h1ABC);

    // R4 R9: Manchester, FSK
    wr_ctrl(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R4 R9", 16'hA500, 8);
    // R8: inverted Manchester
    wr_ctrl(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R8", 16'h5A00, 8);
    // R6: NRZ full buffer
    wr_ctrl(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R6", 16'hC3A5, 16);
    // R3: single bit frame
    run("R3", 16'h8000, 1);
    // R10: OOK with Manchester and NRZ
    wr_ctrl(2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R10", 16'hB200, 8);
    wr_ctrl(2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
    run("R10", 16'h9100, 8);
    // R5: Bi-Phase, level carried between frames
    wr_ctrl(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R5", 16'hB000, 4);
    run("R5", 16'h6000, 5);

    // R12: load and start during a frame are ignored
    wr_ctrl(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    curreq = "R12";
    wr(2'd3, 13'd7);
    load(16'h3C00);
    push_frame(16'h3C00, 8);
    fire();
    repeat (30) @(negedge clk);
    load(16'hFFFF);
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    finish_frame(8);

    // R13: invert written inside bit 0 of an NRZ frame applies from bit 1
    wr_ctrl(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    curreq = "R13";
    wr(2'd3, 13'd3);
    load(16'hF000);
    expq.push_back(item(1'b1));
    expq.push_back(item(1'b1));
    for (int i = 0; i < 6; i++) expq.push_back(item(1'b0));
    fire();
    @(negedge clk);
    wr_ctrl(2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    finish_frame(4);

    // R7 R8: direct mode
    wr_ctrl(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    settle();
    check("R7", "line dbit0", {31'd0, line}, 0);
    check("R7", "car_en FSK", {31'd0, car_en}, 1);
    check("R9", "freq low word", {19'd0, freq_word}, 32'h0123);
    wr_ctrl(2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    settle();
    check("R7", "line dbit1", {31'd0, line}, 1);
    check("R9", "freq high word", {19'd0, freq_word}, 32'h1ABC);
    wr_ctrl(2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
    settle();
    check("R8", "direct inverted", {31'd0, line}, 0);
    wr_ctrl(2'b11, 1'b0, 1'b0, 1'b1, 1'b0);
    settle();
    check("R7", "OOK dbit0 car_en", {31'd0, car_en}, 0);
    wr_ctrl(2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
    settle();
    check("R7", "OOK dbit1 car_en", {31'd0, car_en}, 1);
    check("R10", "OOK freq", {19'd0, freq_word}, 32'h1ABC);

    // R2: band select
    wr_ctrl(2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
    settle();
    check("R2", "car_sel", {31'd0, car_sel}, 1);

    // R1: synchronous settings reset
    @(negedge clk); #1 rf_srst = 1'b1;
    @(negedge clk); #1 rf_srst = 1'b0;
    settle();
    check("R1", "srst car_sel", {31'd0, car_sel}, 0);
    check("R1", "srst freq_word", {19'd0, freq_word}, 0);
    check("R1", "srst car_en", {31'd0, car_en}, 0);
    check("R1", "srst line", {31'd0, line}, 0);
    check("R1", "srst busy", {31'd0, busy}, 0);
    s_code = 2'b00; s_pol = 1'b0; s_cf = 1'b0; s_ook = 1'b0; s_dbit = 1'b0;
    s_wlo = '0; s_whi = '0; s_bp = 1'b0;

    // R1 R5: Bi-Phase level starts low again after the reset
    wr(2'd1, 13'h0456);
    wr(2'd2, 13'h1FFF);
    wr_ctrl(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R1 R5", 16'hE000, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule